// File: doc/BRIEF.md
# Dual Reference Supervisor

This block watches two 8 kHz reference clocks and sets the operating mode of a clock synthesizer's control loop. A select input names which reference the loop should track. The block finds out on its own whether each reference is alive. It enables the phase detector only while the selected reference is healthy. It raises an alarm when the selected reference stops, and it drops into free run when both references are gone or when software forces free run. A tristate request overrides everything else and disables the output pads.

Each reference passes through a two-stage synchronizer and a rising-edge detector. A per-reference watchdog then times the gap since the last edge. All times are parameters counted in system clock cycles: `PERIOD_CYC` is the nominal 125 µs edge spacing, `LATE_CYC` is the 10 µs grace window and `TOL_CYC` is the ±5 % acceptance band. The block never changes the selection itself. On a single loss it freezes the phase detector and alarms, and the surrounding system decides what to do next.

Top module: `dual_ref_supervisor`

## Requirements
- R1: A reference pulse that stays high for at least 4 system clock cycles (32 ns at 125 MHz) counts as a valid edge.
- R2: A present reference is declared lost when no rising edge is seen within `PERIOD_CYC + LATE_CYC` cycles of its previous edge. The alarm for a lost selected reference is high no more than `PERIOD_CYC + LATE_CYC + 8` cycles after the last pulse began.
- R3: A lost reference is declared present again only after two consecutive edges spaced between `PERIOD_CYC - TOL_CYC` and `PERIOD_CYC + TOL_CYC` cycles apart. Edges spaced outside that band do not restore it.
- R4: If only the selected reference is lost: `alarm` = 1, `pd_enable` = 0 and `free_run` = 0, and `ref_sel_out` keeps the value of `ref_sel`. There is no automatic switch.
- R5: Loss of the unselected reference alone leaves `alarm` = 0 and `pd_enable` = 1.
- R6: If both references are lost, `free_run` = 1 and `pd_enable` = 0.
- R7: `force_free` = 1 gives `free_run` = 1 and `pd_enable` = 0 regardless of reference state. In that case `alarm` still reports the selected reference.
- R8: `tristate_req` = 1 has priority over every other input. One cycle later `out_enable` = 0 and `alarm`, `free_run`, `pd_enable` and `ref_sel_out` are all 0.
- R9: When force, tristate or a loss clears, the block returns to tracking. Tracking means `pd_enable` = 1, `free_run` = 0 and `alarm` = 0 once the selected reference is present.
- R10: While `rst_n` = 0 the outputs are `out_enable` = 1, `free_run` = 1, `alarm` = 0, `pd_enable` = 0 and `ref_sel_out` = 0.
- R11: `ref_sel` = 0 selects reference A and 1 selects reference B. `ref_sel_out` follows `ref_sel` one cycle later when no tristate is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_a_in | input | 1 | Reference A, asynchronous 8 kHz pulse train |
| ref_b_in | input | 1 | Reference B, asynchronous 8 kHz pulse train |
| ref_sel | input | 1 | Reference select, 0 = A, 1 = B |
| force_free | input | 1 | Force free run when high |
| tristate_req | input | 1 | Disable all outputs when high |
| alarm | output | 1 | Selected reference lost |
| free_run | output | 1 | Free-run state active |
| pd_enable | output | 1 | Phase detector enable |
| ref_sel_out | output | 1 | Reference being tracked, 0 = A, 1 = B |
| out_enable | output | 1 | Pad output enable |

## Verification
A watchdog counter stuck at the wrong value shows up first on `alarm`. The alarm either rises before the nominal period has passed or is still low past the grace window, so a single pulse interval exposes it. A mode register that decodes wrongly shows a `pd_enable` that disagrees with `free_run` or with the selected reference's health one cycle after the input change. An acceptance band that is too wide lets off-spacing pulses restore the reference, and `alarm` then clears when it should stay set.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TRACK = 2'd1,
    MODE_HOLD  = 2'd2,
    MODE_FREE  = 2'd3
  } ref_mode_e;

  // Mode choice: tristate first, then free run, then hold, then track.
  function automatic ref_mode_e pick_mode(input logic ts, input logic force_fr,
                                          input logic pres_sel, input logic pres_oth);
    if (ts) return MODE_OFF;
    if (force_fr || (!pres_sel && !pres_oth)) return MODE_FREE;
    if (!pres_sel) return MODE_HOLD;
    return MODE_TRACK;
  endfunction

  // Is an edge spacing inside the acceptance band?
  function automatic logic gap_ok(input int unsigned gap, input int unsigned period,
                                  input int unsigned tol);
    return (gap >= period - tol) && (gap <= period + tol);
  endfunction

endpackage

// File: rtl/refmon_edge.sv
module refmon_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/refmon_watch.sv
module refmon_watch
  import refmon_pkg::*;
#(
  parameter int PERIOD_CYC = 15625,
  parameter int LATE_CYC   = 1250,
  parameter int TOL_CYC    = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  output logic present
);
  localparam int LIMIT = PERIOD_CYC + LATE_CYC;
  localparam int CW    = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

  logic [CW-1:0] gap;
  logic          in_band;

  assign in_band = gap_ok(32'(gap), PERIOD_CYC, TOL_CYC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap     <= LIMIT_V;
      present <= 1'b0;
    end else if (rise) begin
      gap <= '0;
      if (!present && in_band) present <= 1'b1;
    end else begin
      if (gap != LIMIT_V) gap <= gap + 1'b1;
      if (gap == LIMIT_V - 1'b1) present <= 1'b0;
    end
  end
endmodule

// File: rtl/refmon_mode.sv
module refmon_mode
  import refmon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ts,
  input  logic       force_fr,
  input  logic       sel,
  input  logic [1:0] pres,
  output logic       alarm,
  output logic       free_run,
  output logic       pd_enable,
  output logic       sel_out,
  output logic       out_enable
);
  ref_mode_e mode;
  logic      alarm_q, sel_q;
  logic      pres_sel, pres_oth;

  assign pres_sel = sel ? pres[1] : pres[0];
  assign pres_oth = sel ? pres[0] : pres[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_FREE;
      alarm_q <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      mode    <= pick_mode(ts, force_fr, pres_sel, pres_oth);
      alarm_q <= !ts && !pres_sel;
      sel_q   <= !ts && sel;
    end
  end

  assign alarm      = alarm_q;
  assign sel_out    = sel_q;
  assign free_run   = (mode == MODE_FREE);
  assign pd_enable  = (mode == MODE_TRACK);
  assign out_enable = (mode != MODE_OFF);
endmodule

// File: rtl/dual_ref_supervisor.sv
module dual_ref_supervisor #(
  parameter int PERIOD_CYC = 15625,
  parameter int LATE_CYC   = 1250,
  parameter int TOL_CYC    = 781,
  parameter int SYNC_STG   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a_in,
  input  logic ref_b_in,
  input  logic ref_sel,
  input  logic force_free,
  input  logic tristate_req,
  output logic alarm,
  output logic free_run,
  output logic pd_enable,
  output logic ref_sel_out,
  output logic out_enable
);
  localparam int NREF = 2;

  logic [NREF-1:0] refs;
  logic [NREF-1:0] rise;
  logic [NREF-1:0] pres;

  assign refs = {ref_b_in, ref_a_in};

  for (genvar i = 0; i < NREF; i++) begin : g_ref
    refmon_edge #(.STAGES(SYNC_STG)) u_edge (
      .clk(clk), .rst_n(rst_n), .din(refs[i]), .rise(rise[i])
    );
    refmon_watch #(.PERIOD_CYC(PERIOD_CYC), .LATE_CYC(LATE_CYC), .TOL_CYC(TOL_CYC)) u_watch (
      .clk(clk), .rst_n(rst_n), .rise(rise[i]), .present(pres[i])
    );
  end

  refmon_mode u_mode (
    .clk(clk), .rst_n(rst_n), .ts(tristate_req), .force_fr(force_free),
    .sel(ref_sel), .pres(pres), .alarm(alarm), .free_run(free_run),
    .pd_enable(pd_enable), .sel_out(ref_sel_out), .out_enable(out_enable)
  );
endmodule

// File: rtl/dual_ref_supervisor_chk.sv
module dual_ref_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_sel,
  input logic       force_free,
  input logic       tristate_req,
  input logic [1:0] rise,
  input logic [1:0] pres,
  input logic       alarm,
  input logic       free_run,
  input logic       pd_enable,
  input logic       ref_sel_out,
  input logic       out_enable
);
  // R3 / R1: presence can only be regained on a detected edge
  a_r3_regain_on_edge_a: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres[0]) |-> $past(rise[0]));
  a_r3_regain_on_edge_b: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pres[1]) |-> $past(rise[1]));
  // R4: alarm follows loss of the selected reference
  a_r4_alarm_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (!tristate_req && !(ref_sel ? pres[1] : pres[0])) |=> alarm);
  // R9: phase detector only runs on a present selected reference
  a_r9_pd_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    pd_enable |-> ($past(ref_sel) ? $past(pres[1]) : $past(pres[0])));
  // R6
  a_r6_both_lost_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!tristate_req && pres == 2'b00) |=> (free_run && !pd_enable));
  // R7
  a_r7_force_free: assert property (@(posedge clk) disable iff (!rst_n)
    (force_free && !tristate_req) |=> (free_run && !pd_enable));
  // R8
  a_r8_tristate_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tristate_req |=> (!out_enable && !pd_enable && !alarm && !free_run));
  // R11 and R4: selection is never changed by the block
  a_r11_sel_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !tristate_req |=> (ref_sel_out == $past(ref_sel)));
endmodule

bind dual_ref_supervisor dual_ref_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_sel(ref_sel), .force_free(force_free),
  .tristate_req(tristate_req), .rise(rise), .pres(pres), .alarm(alarm),
  .free_run(free_run), .pd_enable(pd_enable), .ref_sel_out(ref_sel_out),
  .out_enable(out_enable)
);

// File: tb/dual_ref_supervisor_test.sv
module dual_ref_supervisor_test;
  localparam int PER  = 100;
  localparam int LATE = 10;
  localparam int TOL  = 5;
  localparam int PW   = 4;   // R1: 32 ns pulse width
  localparam int SETTLE = 600;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_a_in = 1'b0, ref_b_in = 1'b0;
  logic ref_sel = 1'b0, force_free = 1'b0, tristate_req = 1'b0;
  logic alarm, free_run, pd_enable, ref_sel_out, out_enable;

  logic live_a = 1'b0, live_b = 1'b0;
  int   gap_a = PER, gap_b = PER;
  int   n_checks = 0, n_fail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  dual_ref_supervisor #(.PERIOD_CYC(PER), .LATE_CYC(LATE), .TOL_CYC(TOL)) uut (
    .clk(clk), .rst_n(rst_n), .ref_a_in(ref_a_in), .ref_b_in(ref_b_in),
    .ref_sel(ref_sel), .force_free(force_free), .tristate_req(tristate_req),
    .alarm(alarm), .free_run(free_run), .pd_enable(pd_enable),
    .ref_sel_out(ref_sel_out), .out_enable(out_enable)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Outputs packed as {out_enable, free_run, alarm, pd_enable, ref_sel_out}
  task automatic chk(input string req, input logic [4:0] exp);
    logic [4:0] got;
    got = {out_enable, free_run, alarm, pd_enable, ref_sel_out};
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (oe fr al pd sel)", req, got, exp);
    end
  endtask

  task automatic chk_bit(input string req, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Reference pulse generators (pulses of PW cycles, R1)
  initial begin
    forever begin
      if (live_a) begin ref_a_in = 1'b1; tick(PW); ref_a_in = 1'b0; tick(gap_a - PW); end
      else tick(1);
    end
  end
  initial begin
    tick(37);
    forever begin
      if (live_b) begin ref_b_in = 1'b1; tick(PW); ref_b_in = 1'b0; tick(gap_b - PW); end
      else tick(1);
    end
  end

  // {ts, force, sel, liveA, liveB, oe, fr, al, pd, sel_out}
  localparam logic [9:0] VEC [10] = '{
    10'b00011_10010,  // R9 R11: track A
    10'b00111_10011,  // R11: track B
    10'b00001_10100,  // R4: A lost, sel A, no switch
    10'b00101_10011,  // R5: unselected A lost
    10'b00110_10101,  // R4: B lost, sel B
    10'b00100_11101,  // R6: both lost
    10'b01011_11000,  // R7: forced free run
    10'b10011_00000,  // R8: tristate
    10'b11000_00000,  // R8: tristate beats force and loss
    10'b00011_10010   // R9: recovery to tracking
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    tick(200000 - 100);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R10 reset state", 5'b11000);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      {tristate_req, force_free, ref_sel, live_a, live_b} = VEC[i][9:5];
      tick(SETTLE);
      chk($sformatf("R1/R4-R9/R11 vector %0d", i), VEC[i][4:0]);
    end

    // R2: alarm timing after the last pulse of the selected reference A
    tristate_req = 1'b0; force_free = 1'b0; ref_sel = 1'b0;
    live_a = 1'b1; live_b = 1'b1;
    tick(SETTLE);
    chk("R2 pre-loss tracking", 5'b10010);
    @(negedge ref_a_in);
    live_a = 1'b0;
    tick(PER - PW - 5);
    chk_bit("R2 alarm not early", alarm, 1'b0);
    tick(LATE + 5 + 8);
    chk_bit("R2 alarm within bound", alarm, 1'b1);
    chk("R4 hold state after loss", 5'b10100);

    // R3: spacing outside the band never restores the reference
    gap_a = PER + 2 * TOL;
    live_a = 1'b1;
    tick(SETTLE);
    chk_bit("R3 off-band spacing keeps alarm", alarm, 1'b1);
    chk_bit("R3 off-band spacing keeps pd off", pd_enable, 1'b0);
    gap_a = PER + TOL - 2;
    tick(SETTLE);
    chk("R3 in-band spacing restores tracking", 5'b10010);

    // R7: force with selected reference lost still reports alarm
    gap_a = PER;
    live_a = 1'b0;
    force_free = 1'b1;
    tick(SETTLE);
    chk("R7 force with selected loss", 5'b11100);
    force_free = 1'b0;
    live_a = 1'b1;
    tick(SETTLE);
    chk("R9 release of force", 5'b10010);

    // R8: one-cycle tristate response
    tristate_req = 1'b1;
    tick(1);
    chk("R8 tristate after one cycle", 5'b00000);
    tristate_req = 1'b0;
    tick(1);
    chk("R8 release of tristate", 5'b10010);

    finish_run();
  end
endmodule